// File: doc/BRIEF.md
# MMU Abort Status Capture

This block holds the abort status word of a paged memory management unit and a companion register that keeps the virtual PC of the current instruction. The address translation stage sends it one strobe per kind of fault: the address lies beyond installed memory, the offset is past the page's length, or the access writes a read-only page. With the strobes it sends the processor mode and the page number of the access. The block records which faults happened, where they happened and which instruction was running. It also issues a trap request with its vector and a pulse that marks the faulting page's descriptor.

Once any error bit is set, the register is frozen. Later faults still add their error bits, but the recorded mode and page stay as they are, and the PC register stops following instruction fetches. Software reads either register through a selected read port. It writes the status word through a write port. A write with the enable bit (bit 0) set also clears the error bits.

Top module: `mmu_abort_status`

## Requirements
- R1: After reset the status word and the PC register read zero, and trap_req and desc_mark are low.
- R2: A non-resident strobe sets status bit 15. In the next cycle trap_req is high with trap_vec = 8'o004.
- R3: A length strobe sets status bit 14 and requests vector 8'o250 in the next cycle. When it arrives together with a non-resident strobe, vector 8'o004 is requested.
- R4: A read-only strobe sets status bits 13 and 12 and raises no trap request on its own.
- R5: A fault arriving while bits 15:13 are all zero writes the mode into bits 6:5 and the page into bits 3:1.
- R6: While any of bits 15:13 is set, frozen is high, and faults leave bits 6:1 unchanged. Their error bits are still ORed in.
- R7: A register write stores wr_data with bits 11:10 forced to zero, so those bits always read zero.
- R8: A write whose bit 0 is set stores bits 15:13 as zero. The other bits are taken from the data.
- R9: When a write and a fault strobe fall in the same cycle, the status word takes the written value.
- R10: A fetch strobe while not frozen loads fetch_pc into the PC register one cycle later. While frozen, the PC register holds its value.
- R11: Every fault strobe gives a one-cycle desc_mark pulse in the next cycle, carrying that fault's page and mode. When desc_mark and trap_req are low, their companion outputs are zero.
- R12: rd_data shows the status word when rd_sel is 0 and the PC register when rd_sel is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_nonres | input | 1 | Non-resident fault strobe |
| flt_length | input | 1 | Page length fault strobe |
| flt_readonly | input | 1 | Read-only write fault strobe |
| flt_mode | input | 2 | Processor mode of the faulting access |
| flt_page | input | 3 | Page number of the faulting access |
| fetch_start | input | 1 | Start of instruction fetch |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| wr_en | input | 1 | Status register write |
| wr_data | input | 16 | Status write data |
| rd_sel | input | 1 | Read select: 0 status, 1 PC |
| rd_data | output | RD_W | Selected register |
| status | output | 16 | Status word |
| vpc | output | PC_W | Latched PC |
| frozen | output | 1 | Error bits present |
| trap_req | output | 1 | Trap request pulse |
| trap_vec | output | 8 | Trap vector |
| desc_mark | output | 1 | Descriptor mark pulse |
| mark_page | output | 3 | Page to mark |
| mark_mode | output | 2 | Mode of the page to mark |

## Verification
The assertions check on every cycle that error bits appear after their strobes, that bits 11:10 stay zero, that a clearing write empties bits 15:13, and that a frozen register keeps bits 6:1 and the PC. They also check the trap vector and the mark pulse timing. Only the bench scenarios can show the full recorded values: mode and page from the first fault, write-wins arbitration, accumulation of later error bits, and the read multiplexer. The bench compares every output against a reference model across random streams of faults, fetches and writes.

// File: rtl/mmu_abort_pkg.sv
package mmu_abort_pkg;
  localparam int ST_W     = 16;
  localparam int MODE_W   = 2;
  localparam int PAGE_W   = 3;
  localparam int VEC_W    = 8;
  localparam int B_NONRES = 15;
  localparam int B_LENGTH = 14;
  localparam int B_RDONLY = 13;
  localparam int B_TRAP   = 12;
  localparam int MODE_LO  = 5;
  localparam int PAGE_LO  = 1;
  localparam int B_ENABLE = 0;
  localparam logic [ST_W-1:0] ZERO_MASK = 16'h0C00;
  localparam logic [VEC_W-1:0] VEC_NONRES = 8'o004;
  localparam logic [VEC_W-1:0] VEC_LENGTH = 8'o250;

  typedef struct packed {
    logic nonres;
    logic length;
    logic rdonly;
  } fault_t;
endpackage

// File: rtl/abort_rst_sync.sv
module abort_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/abort_fault_encode.sv
module abort_fault_encode
  import mmu_abort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fault_t            flt,
  input  logic [MODE_W-1:0] mode,
  input  logic [PAGE_W-1:0] page,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec,
  output logic              mark,
  output logic [PAGE_W-1:0] mark_page,
  output logic [MODE_W-1:0] mark_mode
);
  logic              req_d, mark_d;
  logic [VEC_W-1:0]  vec_d;
  logic [PAGE_W-1:0] page_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    req_d  = flt.nonres | flt.length;
    mark_d = flt.nonres | flt.length | flt.rdonly;
    vec_d  = '0;
    if (flt.nonres)      vec_d = VEC_NONRES;
    else if (flt.length) vec_d = VEC_LENGTH;
    page_d = mark_d ? page : '0;
    mode_d = mark_d ? mode : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      mark      <= 1'b0;
      mark_page <= '0;
      mark_mode <= '0;
    end else begin
      trap_req  <= req_d;
      trap_vec  <= vec_d;
      mark      <= mark_d;
      mark_page <= page_d;
      mark_mode <= mode_d;
    end
  end

  a_r2_nonres_vector: assert property (@(posedge clk) disable iff (!rst_n)
    flt.nonres |=> (trap_req && trap_vec == VEC_NONRES));
  a_r3_length_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.length && !flt.nonres) |=> (trap_req && trap_vec == VEC_LENGTH));
  a_r4_rdonly_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.rdonly && !flt.nonres && !flt.length) |=> !trap_req);
  a_r11_mark_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.nonres || flt.length || flt.rdonly) |=> (mark && mark_page == $past(page)));
endmodule

// File: rtl/abort_status_reg.sv
module abort_status_reg
  import mmu_abort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fault_t            flt,
  input  logic [MODE_W-1:0] mode,
  input  logic [PAGE_W-1:0] page,
  input  logic              wr_en,
  input  logic [ST_W-1:0]   wr_data,
  output logic [ST_W-1:0]   status,
  output logic              frozen
);
  logic [ST_W-1:0] st_q, st_d;
  logic            any_flt, st_en;

  assign any_flt = flt.nonres | flt.length | flt.rdonly;
  assign st_en   = wr_en | any_flt;
  assign frozen  = |st_q[B_NONRES:B_RDONLY];

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      st_d = wr_data & ~ZERO_MASK;
      if (wr_data[B_ENABLE]) st_d[B_NONRES:B_RDONLY] = '0;
    end else if (any_flt) begin
      st_d[B_NONRES] = st_q[B_NONRES] | flt.nonres;
      st_d[B_LENGTH] = st_q[B_LENGTH] | flt.length;
      st_d[B_RDONLY] = st_q[B_RDONLY] | flt.rdonly;
      st_d[B_TRAP]   = st_q[B_TRAP]   | flt.rdonly;
      if (!frozen) begin
        st_d[MODE_LO +: MODE_W] = mode;
        st_d[PAGE_LO +: PAGE_W] = page;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;

  a_r2_nonres_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.nonres && !wr_en) |=> status[B_NONRES]);
  a_r4_rdonly_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flt.rdonly && !wr_en) |=> (status[B_RDONLY] && status[B_TRAP]));
  a_r6_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && any_flt && !wr_en) |=> $stable(status[6:1]));
  a_r7_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status[11:10] == 2'b00);
  a_r8_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_ENABLE]) |=> (status[B_NONRES:B_RDONLY] == 3'b000));
endmodule

// File: rtl/abort_pc_latch.sv
module abort_pc_latch #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch,
  input  logic            hold,
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] vpc
);
  logic            pc_en;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    pc_en = fetch & ~hold;
    pc_d  = pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vpc <= '0;
    else if (pc_en) vpc <= pc_d;
  end

  a_r10_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(vpc));
  a_r10_load_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !hold) |=> (vpc == $past(pc)));
endmodule

// File: rtl/mmu_abort_status.sv
module mmu_abort_status
  import mmu_abort_pkg::*;
#(
  parameter int PC_W = 16,
  localparam int RD_W = (PC_W > ST_W) ? PC_W : ST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_nonres,
  input  logic              flt_length,
  input  logic              flt_readonly,
  input  logic [1:0]        flt_mode,
  input  logic [2:0]        flt_page,
  input  logic              fetch_start,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              rd_sel,
  output logic [RD_W-1:0]   rd_data,
  output logic [15:0]       status,
  output logic [PC_W-1:0]   vpc,
  output logic              frozen,
  output logic              trap_req,
  output logic [7:0]        trap_vec,
  output logic              desc_mark,
  output logic [2:0]        mark_page,
  output logic [1:0]        mark_mode
);
  logic   rst_n_i;
  fault_t flt;

  assign flt = '{nonres: flt_nonres, length: flt_length, rdonly: flt_readonly};

  abort_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  abort_status_reg u_status (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .flt     (flt),
    .mode    (flt_mode),
    .page    (flt_page),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .status  (status),
    .frozen  (frozen)
  );

  abort_pc_latch #(.PC_W(PC_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .fetch (fetch_start),
    .hold  (frozen),
    .pc    (fetch_pc),
    .vpc   (vpc)
  );

  abort_fault_encode u_enc (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .flt       (flt),
    .mode      (flt_mode),
    .page      (flt_page),
    .trap_req  (trap_req),
    .trap_vec  (trap_vec),
    .mark      (desc_mark),
    .mark_page (mark_page),
    .mark_mode (mark_mode)
  );

  assign rd_data = rd_sel ? RD_W'(vpc) : RD_W'(status);
endmodule

// File: tb/tb_mmu_abort_status.sv
`timescale 1ns/1ps
module tb_mmu_abort_status;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nr, ln, ro, fetch, wr, sel;
  logic [1:0]  mode;
  logic [2:0]  page;
  logic [15:0] pc, wdata;
  logic [15:0] rd_data, status, vpc;
  logic        frozen, trap_req, desc_mark;
  logic [7:0]  trap_vec;
  logic [2:0]  mark_page;
  logic [1:0]  mark_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] e_st, e_pc;
  logic        e_trap, e_mark;
  logic [7:0]  e_vec;
  logic [2:0]  e_mpage;
  logic [1:0]  e_mmode;

  always #4 clk = ~clk;

  mmu_abort_status dut (
    .clk(clk), .rst_n(rst_n), .flt_nonres(nr), .flt_length(ln), .flt_readonly(ro),
    .flt_mode(mode), .flt_page(page), .fetch_start(fetch), .fetch_pc(pc),
    .wr_en(wr), .wr_data(wdata), .rd_sel(sel), .rd_data(rd_data), .status(status),
    .vpc(vpc), .frozen(frozen), .trap_req(trap_req), .trap_vec(trap_vec),
    .desc_mark(desc_mark), .mark_page(mark_page), .mark_mode(mark_mode)
  );

  function automatic logic [15:0] model_status(logic [15:0] cur, logic w, logic [15:0] d,
      logic f_nr, logic f_ln, logic f_ro, logic [1:0] m, logic [2:0] p);
    logic [15:0] n;
    n = cur;
    if (w) begin
      n = d & 16'hF3FF;
      if (d[0]) n[15:13] = 3'b000;
    end else if (f_nr | f_ln | f_ro) begin
      if (cur[15:13] == 3'b000) begin
        n[6:5] = m;
        n[3:1] = p;
      end
      n[15] = n[15] | f_nr;
      n[14] = n[14] | f_ln;
      n[13] = n[13] | f_ro;
      n[12] = n[12] | f_ro;
    end
    return n;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "status", status, e_st);
    check(tag, "vpc", vpc, e_pc);
    check(tag, "frozen", 16'(frozen), 16'(e_st[15:13] != 3'b000));
    check(tag, "trap_req", 16'(trap_req), 16'(e_trap));
    check(tag, "trap_vec", 16'(trap_vec), 16'(e_vec));
    check(tag, "desc_mark", 16'(desc_mark), 16'(e_mark));
    check(tag, "mark_page", 16'(mark_page), 16'(e_mpage));
    check(tag, "mark_mode", 16'(mark_mode), 16'(e_mmode));
    sel = 1'b0; #1;
    check("R12", "rd status", rd_data, e_st);
    sel = 1'b1; #1;
    check("R12", "rd vpc", rd_data, e_pc);
  endtask

  // Called at a falling edge with inputs set; advances one cycle and checks.
  task automatic cycle(string tag);
    logic any;
    any = nr | ln | ro;
    e_trap  = nr | ln;
    e_vec   = nr ? 8'o004 : (ln ? 8'o250 : 8'h00);
    e_mark  = any;
    e_mpage = any ? page : 3'b000;
    e_mmode = any ? mode : 2'b00;
    if (fetch && e_st[15:13] == 3'b000) e_pc = pc;
    e_st = model_status(e_st, wr, wdata, nr, ln, ro, mode, page);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    nr = 0; ln = 0; ro = 0; fetch = 0; wr = 0;
  endtask

  task automatic idle_inputs();
    nr = 0; ln = 0; ro = 0; fetch = 0; wr = 0; sel = 0;
    mode = 0; page = 0; pc = 0; wdata = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst_n = 1'b0;
    e_st = 0; e_pc = 0; e_trap = 0; e_vec = 0; e_mark = 0; e_mpage = 0; e_mmode = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R10: fetch capture while not frozen
    fetch = 1; pc = 16'o001234; cycle("R10");
    // R2 + R5: non-resident, mode and page captured
    nr = 1; mode = 2'b11; page = 3'd5; cycle("R2");
    check("R5", "mode/page", {9'b0, status[6:1]}, {9'b0, 2'b11, 1'b0, 3'd5});
    // R6 + R10: frozen; later faults keep 6:1, PC holds
    ln = 1; mode = 2'b01; page = 3'd2; fetch = 1; pc = 16'o7777; cycle("R6");
    ro = 1; mode = 2'b00; page = 3'd7; cycle("R6");
    // R8: clearing write
    wr = 1; wdata = 16'hFFFF; cycle("R8");
    // R7: write without enable keeps 15:13, zeroes 11:10
    wr = 1; wdata = 16'hEC00; cycle("R7");
    wr = 1; wdata = 16'h0001; cycle("R8");
    // R4: read-only only, no trap
    ro = 1; mode = 2'b10; page = 3'd1; cycle("R4");
    wr = 1; wdata = 16'h0001; cycle("R8");
    // R3: length alone, then both with non-resident priority
    ln = 1; page = 3'd4; cycle("R3");
    wr = 1; wdata = 16'h0001; cycle("R8");
    nr = 1; ln = 1; mode = 2'b01; page = 3'd6; cycle("R3");
    // R9: write and fault together
    wr = 1; wdata = 16'h0021; ro = 1; page = 3'd3; cycle("R9");
    // R11: mark carries page/mode of first fault after clear
    ln = 1; mode = 2'b10; page = 3'd7; cycle("R11");
    cycle("R11");

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      nr = (r < 4);
      ln = (r >= 3 && r < 8);
      ro = (r >= 7 && r < 12);
      mode = 2'($urandom);
      page = 3'($urandom);
      fetch = ($urandom_range(0, 3) == 0);
      pc = 16'($urandom);
      wr = ($urandom_range(0, 19) == 0);
      wdata = 16'($urandom);
      if ($urandom_range(0, 1) == 1) wdata[0] = 1'b1;
      cycle("R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule